// File: doc/BRIEF.md
# Authenticated Debug Access Controller

This block decides, for each of a small number of external debug ports, whether that port may reach the system. Two inputs shape the decision. The first is the device lifecycle state. The second is a policy held in a write-once configuration store. The store keeps one policy word for the normal lifecycle state and another, fuse-like, for the secure lifecycle state. In each word every port has a two-bit field that selects open, authenticated or blocked access.

When a port is under authenticated policy, it comes out of reset blocked. A trusted security processor then drives it through a register port that carries disable, enable and limited-window bits. The security processor first opens a limited window, which grants mailbox-only access so that a credential can be exchanged. Once it has validated the credential, it may widen that window to full debug access. Writes that come from any other bus master are dropped and flagged. Credential checking, cryptography and the mailbox itself lie outside this block.

Top module: `dbg_access_ctrl`

## Requirements
- R1: With `lc_secure` low the policy comes from the normal word; with it high, from the secure word. Port p uses bits [2p+1:2p] of the selected word.
- R2: Store bits start at 0. A store write ORs its data into the chosen word, so a bit only ever goes from 0 to 1. Warm reset leaves the store unchanged.
- R3: Policy 00 (open) gives full access (`dbg_full_en` high) on the first clock edge after reset is released. While `rst` is high, every access output and `ctl_err` are low.
- R4: Policy 01 (authenticated) leaves the port blocked after reset, with both `dbg_full_en` and `dbg_mbox_en` low.
- R5: Policy 10 or 11 forces the port blocked on the edge after that policy is seen, and every enable write to that port is ignored.
- R6: A security-processor write with enable=1, limited=1 and disable=0 moves the port to mailbox-only access (`dbg_mbox_en` high, `dbg_full_en` low) on the next edge. This applies to an authenticated port that is blocked, and to a port that is already limited or unlocked.
- R7: A write with enable=1, limited=0 and disable=0 grants full access only from the limited state. The same write to a blocked port has no effect.
- R8: A security-processor write with disable=1 returns a limited or unlocked port to blocked on the next edge, whatever the other bits are. An open-policy port that has been blocked this way stays blocked until reset.
- R9: A write whose `ctl_master` differs from the security-processor ID (parameter `HSM_ID`, default 5) changes nothing, and `ctl_err` is high for exactly the following cycle.
- R10: A control write affects only the port that `ctl_port` selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high warm reset |
| lc_secure | input | 1 | Lifecycle: 0 normal, 1 secure |
| cfg_wr_en | input | 1 | Store write strobe |
| cfg_wr_secure | input | 1 | Store word select: 0 normal, 1 secure |
| cfg_wr_data | input | 2*NPORTS | Bits ORed into the selected store word |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_master | input | MASTER_W | ID of the writing bus master |
| ctl_port | input | PORT_W | Debug port addressed by the write |
| ctl_disable | input | 1 | Disable bit |
| ctl_enable | input | 1 | Enable bit |
| ctl_limited | input | 1 | Limited-window flag |
| dbg_full_en | output | NPORTS | Full debug access per port |
| dbg_mbox_en | output | NPORTS | Mailbox-only access per port |
| ctl_err | output | 1 | Dropped-write flag, one cycle |

## Verification
Two things are hard to reach from the ports. The first is a single command applied to an authenticated port in each of its reachable states. Because the store is sticky, the second is any test of policies that depend on the order of the sweep. The bench therefore programs the store once with an authenticated port and a blocked port. It then relies on warm reset, which leaves the store intact, to return to a clean start before each trial. For each trial it walks port 0 into blocked, limited or unlocked state. From there it applies all eight control-bit patterns, once from the security processor and once from a foreign master, and compares the result with a next-state model written from the requirements. Later phases write zeros to show that the store cannot be reopened, and switch to the secure lifecycle word.

// File: rtl/dbg_acc_pkg.sv
package dbg_acc_pkg;

  typedef enum logic [1:0] {
    ST_BOOT     = 2'd0,
    ST_BLOCKED  = 2'd1,
    ST_LIMITED  = 2'd2,
    ST_UNLOCKED = 2'd3
  } dbg_state_e;

  localparam logic [1:0] POL_OPEN = 2'b00;
  localparam logic [1:0] POL_AUTH = 2'b01;

  typedef struct packed {
    logic dis;
    logic en;
    logic lim;
  } ctl_cmd_t;

endpackage

// File: rtl/dbg_cfg_store.sv
module dbg_cfg_store #(
  parameter int NPORTS = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  wr_secure,
  input  logic [2*NPORTS-1:0]   wr_data,
  input  logic                  lc_secure,
  output logic [2*NPORTS-1:0]   policy_o
);
  localparam int W = 2 * NPORTS;

  // One-way bits: preset at power-up only, never touched by warm reset.
  logic [W-1:0] normal_q = '0;
  logic [W-1:0] secure_q = '0;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (wr_secure) secure_q <= secure_q | wr_data;
      else           normal_q <= normal_q | wr_data;
    end
  end

  always_comb policy_o = lc_secure ? secure_q : normal_q;

  // R2: a set bit never clears, whatever is written or however reset toggles
  a_r2_normal_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((normal_q & $past(normal_q)) == $past(normal_q)));
  a_r2_secure_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((secure_q & $past(secure_q)) == $past(secure_q)));

endmodule

// File: rtl/dbg_port_fsm.sv
module dbg_port_fsm
  import dbg_acc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic [1:0] pol_i,
  input  logic      hit_i,
  input  ctl_cmd_t  cmd_i,
  output logic      full_o,
  output logic      mbox_o
);
  dbg_state_e st_q, st_d;
  logic       full_q, mbox_q;

  always_comb begin
    st_d = st_q;
    if (pol_i[1]) begin
      st_d = ST_BLOCKED;
    end else if (st_q == ST_BOOT) begin
      st_d = (pol_i == POL_OPEN) ? ST_UNLOCKED : ST_BLOCKED;
    end else if (hit_i) begin
      if (cmd_i.dis) begin
        st_d = ST_BLOCKED;
      end else if (cmd_i.en && cmd_i.lim) begin
        if (st_q != ST_BLOCKED || pol_i == POL_AUTH) st_d = ST_LIMITED;
      end else if (cmd_i.en) begin
        if (st_q == ST_LIMITED) st_d = ST_UNLOCKED;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_BOOT;
      full_q <= 1'b0;
      mbox_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      full_q <= (st_d == ST_UNLOCKED);
      mbox_q <= (st_d == ST_LIMITED);
    end
  end

  assign full_o = full_q;
  assign mbox_o = mbox_q;

  // R5: a blocking policy closes both paths on the next edge
  a_r5_policy_blocks: assert property (@(posedge clk) disable iff (rst)
    pol_i[1] |=> (!full_q && !mbox_q));
  // R7: under authenticated policy full access is reached only via the window
  a_r7_only_via_window: assert property (@(posedge clk) disable iff (rst)
    (pol_i == POL_AUTH && !full_q && st_q != ST_LIMITED) |=> !full_q);
  // R6: window opens from blocked on an accepted request
  a_r6_window_opens: assert property (@(posedge clk) disable iff (rst)
    (hit_i && cmd_i.en && cmd_i.lim && !cmd_i.dis && st_q == ST_BLOCKED
     && pol_i == POL_AUTH) |=> (mbox_q && !full_q));
  // R8: disable wins from limited or unlocked
  a_r8_disable_closes: assert property (@(posedge clk) disable iff (rst)
    (hit_i && cmd_i.dis && (st_q == ST_LIMITED || st_q == ST_UNLOCKED))
    |=> (!full_q && !mbox_q));

endmodule

// File: rtl/dbg_access_ctrl.sv
module dbg_access_ctrl
  import dbg_acc_pkg::*;
#(
  parameter int          NPORTS   = 2,
  parameter int          MASTER_W = 4,
  parameter int          HSM_ID   = 5,
  localparam int         PORT_W   = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  lc_secure,
  input  logic                  cfg_wr_en,
  input  logic                  cfg_wr_secure,
  input  logic [2*NPORTS-1:0]   cfg_wr_data,
  input  logic                  ctl_wr_en,
  input  logic [MASTER_W-1:0]   ctl_master,
  input  logic [PORT_W-1:0]     ctl_port,
  input  logic                  ctl_disable,
  input  logic                  ctl_enable,
  input  logic                  ctl_limited,
  output logic [NPORTS-1:0]     dbg_full_en,
  output logic [NPORTS-1:0]     dbg_mbox_en,
  output logic                  ctl_err
);
  localparam logic [MASTER_W-1:0] TRUSTED = MASTER_W'(HSM_ID);

  logic [2*NPORTS-1:0] policy;
  logic                trusted_wr;
  ctl_cmd_t            cmd;
  logic                err_q;

  assign trusted_wr = ctl_wr_en && (ctl_master == TRUSTED);
  assign cmd = '{dis: ctl_disable, en: ctl_enable, lim: ctl_limited};

  dbg_cfg_store #(.NPORTS(NPORTS)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cfg_wr_en),
    .wr_secure (cfg_wr_secure),
    .wr_data   (cfg_wr_data),
    .lc_secure (lc_secure),
    .policy_o  (policy)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic hit;
    assign hit = trusted_wr && (ctl_port == PORT_W'(p));
    dbg_port_fsm u_fsm (
      .clk    (clk),
      .rst    (rst),
      .pol_i  (policy[2*p +: 2]),
      .hit_i  (hit),
      .cmd_i  (cmd),
      .full_o (dbg_full_en[p]),
      .mbox_o (dbg_mbox_en[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= ctl_wr_en && (ctl_master != TRUSTED);
  end
  assign ctl_err = err_q;

  // R9: a foreign write is flagged on the next cycle
  a_r9_foreign_flagged: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr_en && ctl_master != TRUSTED) |=> ctl_err);
  // R9: the flag never rises without a foreign write before it
  a_r9_flag_cause: assert property (@(posedge clk) disable iff (rst)
    !(ctl_wr_en && ctl_master != TRUSTED) |=> !ctl_err);

endmodule

// File: tb/dbg_access_ctrl_bench.sv
module dbg_access_ctrl_bench;
  localparam int NP = 2;
  localparam int MW = 4;
  localparam int HID = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lc_secure = 1'b0;
  logic cfg_wr_en = 1'b0, cfg_wr_secure = 1'b0;
  logic [2*NP-1:0] cfg_wr_data = '0;
  logic ctl_wr_en = 1'b0;
  logic [MW-1:0] ctl_master = '0;
  logic [0:0] ctl_port = '0;
  logic ctl_disable = 1'b0, ctl_enable = 1'b0, ctl_limited = 1'b0;
  logic [NP-1:0] dbg_full_en, dbg_mbox_en;
  logic ctl_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dbg_access_ctrl #(.NPORTS(NP), .MASTER_W(MW), .HSM_ID(HID)) u_dbg_access_ctrl (
    .clk(clk), .rst(rst), .lc_secure(lc_secure),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_secure(cfg_wr_secure), .cfg_wr_data(cfg_wr_data),
    .ctl_wr_en(ctl_wr_en), .ctl_master(ctl_master), .ctl_port(ctl_port),
    .ctl_disable(ctl_disable), .ctl_enable(ctl_enable), .ctl_limited(ctl_limited),
    .dbg_full_en(dbg_full_en), .dbg_mbox_en(dbg_mbox_en), .ctl_err(ctl_err)
  );

  // state codes in the model: 0 boot, 1 blocked, 2 limited, 3 unlocked
  function automatic int model(int st, logic [1:0] pol, bit hit, bit dis, bit en, bit lim);
    if (pol[1]) return 1;
    if (st == 0) return (pol == 2'b00) ? 3 : 1;
    if (!hit) return st;
    if (dis) return 1;
    if (en && lim) return (st != 1 || pol == 2'b01) ? 2 : st;
    if (en) return (st == 2) ? 3 : st;
    return st;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic cfg_write(bit sec, logic [2*NP-1:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_secure = sec; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_wr_data = '0;
  endtask

  // drive one control write for one cycle; returns at the next negedge
  task automatic ctl_write(int port, int master, bit dis, bit en, bit lim);
    ctl_wr_en = 1'b1; ctl_port = 1'(port); ctl_master = MW'(master);
    ctl_disable = dis; ctl_enable = en; ctl_limited = lim;
    @(negedge clk);
    ctl_wr_en = 1'b0; ctl_disable = 1'b0; ctl_enable = 1'b0; ctl_limited = 1'b0;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    // R3: reset state
    check("R3 reset full", 32'(dbg_full_en), 0);
    check("R3 reset mbox", 32'(dbg_mbox_en), 0);
    check("R3 reset err", 32'(ctl_err), 0);
    rst = 1'b0;
    @(negedge clk);
    // R3 / R1: both words empty, normal lifecycle => open on first edge
    check("R3 open after reset", 32'(dbg_full_en), 32'b11);
    check("R1 normal word open mbox", 32'(dbg_mbox_en), 0);

    // port0 authenticated (01), port1 blocked (10)
    cfg_write(1'b0, 4'b1001);
    do_reset();
    check("R4 auth blocked full", 32'(dbg_full_en), 0);
    check("R4 auth blocked mbox", 32'(dbg_mbox_en), 0);

    // sweep start state x command x master on port0
    for (int s = 1; s <= 3; s++) begin
      for (int c = 0; c < 8; c++) begin
        for (int m = 0; m < 2; m++) begin
          int exp_st;
          bit hsm;
          hsm = (m == 0);
          do_reset();
          if (s >= 2) ctl_write(0, HID, 1'b0, 1'b1, 1'b1);
          if (s == 3) ctl_write(0, HID, 1'b0, 1'b1, 1'b0);
          check("R6 reach start", 32'({dbg_full_en[0], dbg_mbox_en[0]}),
                32'({s == 3, s == 2}));
          ctl_write(0, hsm ? HID : 9, c[2], c[1], c[0]);
          exp_st = model(s, 2'b01, hsm, c[2], c[1], c[0]);
          if (!hsm) check("R9 foreign err", 32'(ctl_err), 1);
          else      check("R9 trusted no err", 32'(ctl_err), 0);
          if (c[2] && hsm)
            check("R8 disable", 32'({dbg_full_en[0], dbg_mbox_en[0]}),
                  32'({exp_st == 3, exp_st == 2}));
          else if (c[1] && !c[0])
            check("R7 widen", 32'({dbg_full_en[0], dbg_mbox_en[0]}),
                  32'({exp_st == 3, exp_st == 2}));
          else
            check("R6 window", 32'({dbg_full_en[0], dbg_mbox_en[0]}),
                  32'({exp_st == 3, exp_st == 2}));
          check("R10 other port untouched", 32'({dbg_full_en[1], dbg_mbox_en[1]}), 0);
          @(negedge clk);
          check("R9 err one cycle", 32'(ctl_err), 0);
        end
      end
    end

    // R5: enable sequence on the blocked port is ignored
    do_reset();
    ctl_write(1, HID, 1'b0, 1'b1, 1'b1);
    check("R5 blocked ignores window", 32'({dbg_full_en[1], dbg_mbox_en[1]}), 0);
    ctl_write(1, HID, 1'b0, 1'b1, 1'b0);
    check("R5 blocked ignores widen", 32'({dbg_full_en[1], dbg_mbox_en[1]}), 0);

    // R10: opening port0 leaves port1 alone; R7 direct widen from blocked ignored
    ctl_write(0, HID, 1'b0, 1'b1, 1'b0);
    check("R7 no direct unlock", 32'(dbg_full_en), 0);

    // R2: zero write cannot reopen, warm reset keeps store
    cfg_write(1'b0, 4'b0000);
    do_reset();
    check("R2 store kept", 32'({dbg_full_en, dbg_mbox_en}), 0);

    // R1: secure lifecycle uses the still-empty secure word
    lc_secure = 1'b1;
    do_reset();
    check("R1 secure word open", 32'(dbg_full_en), 32'b11);
    cfg_write(1'b1, 4'b0011);
    do_reset();
    check("R1 secure port0 blocked", 32'(dbg_full_en), 32'b10);
    // R8: open port disabled stays blocked even after an enable request
    ctl_write(1, HID, 1'b1, 1'b0, 1'b0);
    check("R8 open port disabled", 32'(dbg_full_en), 0);
    ctl_write(1, HID, 1'b0, 1'b1, 1'b1);
    check("R8 open port stays blocked", 32'({dbg_full_en, dbg_mbox_en}), 0);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule